// File: doc/BRIEF.md
# Watermark-Triggered Burst Length Planner

This block sits inside the internal DMA engine of an SD host controller, between the data buffer and the bus master. It decides when the engine may start a burst and how many 32-bit words that burst carries. In the read direction it compares the number of words waiting in the buffer with a programmable watermark. In the write direction it compares the free space with the same watermark. Once the level is above the watermark, it raises a request towards the bus master that carries the start address, the length and the burst kind.

The length is the smallest of five limits. Four always apply: the configured maximum burst length, the watermark value itself, the words left in the current block, and the words left before the next 1 KB address boundary. The fifth is the words left in the current descriptor, which applies only when descriptor-based DMA is switched on.

A transfer is opened by a start pulse, which loads the address, the block length and the descriptor length. After each finished burst the block advances its own address and counts down its remaining lengths, so the addresses it issues stay strictly sequential.

The controller has four states, and every transition is listed here:
- IDLE goes to WAIT_LEVEL on a start pulse.
- WAIT_LEVEL goes back to IDLE when the block count has reached zero.
- WAIT_LEVEL goes to REQUEST when the level is above the watermark and the smallest limit is not zero.
- REQUEST goes to BURSTING when the bus master accepts the request.
- BURSTING goes to WAIT_LEVEL when the burst is reported complete.

Top module: `burst_planner`

## Requirements
- R1: In the read direction (`dir_write`=0), a request is raised only when `fill_words` is strictly greater than `wml`.
- R2: In the write direction (`dir_write`=1), the same rule applies to `free_words`, and `fill_words` has no effect.
- R3: `req_len` is the minimum of `cfg_burst`, `wml`, the remaining block words, and (1024 − (address mod 1024))/4. A burst therefore never crosses a 1 KB boundary.
- R4: When `adma_en`=1, the remaining descriptor words are a fifth limit in that minimum.
- R5: When `adma_en`=0, the descriptor count is ignored and is treated as unlimited.
- R6: `req_kind` is 3'b011 for a 4-word burst, 3'b101 for an 8-word burst, and 3'b001 for any other length.
- R7: A zero-length request is never raised. If any limit is zero, no request appears.
- R8: After `burst_done`, the next request address is the previous address plus 4×length. The block count and, when `adma_en`=1, the descriptor count both drop by the length.
- R9: A raised request holds its address, length and kind until `req_ready`. A start pulse while a transfer is open is ignored.
- R10: After reset the block is idle with `req_valid`=0.
- R11: When the remaining block words reach zero, the block returns to idle and accepts a new start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Pulse that opens a transfer |
| start_addr | input | ADDR_W | Word-aligned start byte address |
| blk_words | input | CNT_W | Block length in words |
| desc_words | input | CNT_W | Descriptor length in words |
| adma_en | input | 1 | Descriptor-length limit enabled |
| dir_write | input | 1 | 1 = write (use free space), 0 = read (use fill level) |
| fill_words | input | CNT_W | Words held in the buffer |
| free_words | input | CNT_W | Free words in the buffer |
| wml | input | LEN_W | Watermark level in words |
| cfg_burst | input | LEN_W | Configured maximum burst length |
| req_ready | input | 1 | Bus master accepts the request |
| burst_done | input | 1 | Accepted burst has finished |
| req_valid | output | 1 | Burst request |
| req_addr | output | ADDR_W | Burst start address |
| req_len | output | CNT_W | Burst length in words |
| req_kind | output | 3 | Burst kind code |

## Verification
A behavioural reference model is stepped alongside the design and compared with it on every clock. Directed scenarios then steer the minimum so that a different limit wins each time:
- A long block where the configured length wins yields 8-word bursts.
- A start address just below a 1 KB line gives a 3-word burst, followed by a longer one once the line is crossed.
- A short descriptor stalls the transfer until descriptor mode is dropped, which separates R4 from R5.
- A zero watermark and a full-but-unused fill level in write mode each prove that the request stays low.
- A held request with a stray start pulse shows that the fields are frozen.

// File: rtl/burst_planner_pkg.sv
package burst_planner_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WAIT_LEVEL,
        S_REQUEST,
        S_BURSTING
    } plan_state_t;

    typedef enum logic [2:0] {
        KIND_INCR  = 3'b001,
        KIND_INCR4 = 3'b011,
        KIND_INCR8 = 3'b101
    } burst_kind_t;

endpackage

// File: rtl/burst_limit_min.sv
module burst_limit_min #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CNT_W-1:0]  blk_left,
    input  logic [CNT_W-1:0]  desc_left,
    input  logic              adma_en,
    input  logic [LEN_W-1:0]  wml,
    input  logic [LEN_W-1:0]  cfg_burst,
    output logic [CNT_W-1:0]  limit
);
    localparam int NLIM = 5;
    localparam int KB_W = 11;

    logic [KB_W-1:0]  kb_bytes;
    logic [CNT_W-1:0] cand [NLIM];

    // Bytes left before the next 1 KB line, range 4..1024
    assign kb_bytes = 11'd1024 - {1'b0, cur_addr[9:0]};

    assign cand[0] = CNT_W'(cfg_burst);
    assign cand[1] = CNT_W'(wml);
    assign cand[2] = blk_left;
    assign cand[3] = CNT_W'(kb_bytes >> 2);
    assign cand[4] = adma_en ? desc_left : {CNT_W{1'b1}};

    always_comb begin
        limit = cand[0];
        for (int i = 1; i < NLIM; i++) begin
            if (cand[i] < limit) limit = cand[i];
        end
    end
endmodule

// File: rtl/burst_kind_sel.sv
module burst_kind_sel
    import burst_planner_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] len,
    output burst_kind_t      kind
);
    always_comb begin
        unique case (len)
            CNT_W'(4): kind = KIND_INCR4;
            CNT_W'(8): kind = KIND_INCR8;
            default:   kind = KIND_INCR;
        endcase
    end
endmodule

// File: rtl/burst_planner.sv
module burst_planner
    import burst_planner_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  blk_words,
    input  logic [CNT_W-1:0]  desc_words,
    input  logic              adma_en,
    input  logic              dir_write,
    input  logic [CNT_W-1:0]  fill_words,
    input  logic [CNT_W-1:0]  free_words,
    input  logic [LEN_W-1:0]  wml,
    input  logic [LEN_W-1:0]  cfg_burst,
    input  logic              req_ready,
    input  logic              burst_done,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [CNT_W-1:0]  req_len,
    output logic [2:0]        req_kind
);
    plan_state_t      state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  blk_q, desc_q, len_q;
    logic [CNT_W-1:0]  limit, level;
    burst_kind_t       kind_q, kind_c;
    logic              level_ok;

    burst_limit_min #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) i_limit (
        .cur_addr (addr_q),
        .blk_left (blk_q),
        .desc_left(desc_q),
        .adma_en  (adma_en),
        .wml      (wml),
        .cfg_burst(cfg_burst),
        .limit    (limit)
    );

    burst_kind_sel #(.CNT_W(CNT_W)) i_kind (
        .len (limit),
        .kind(kind_c)
    );

    assign level    = dir_write ? free_words : fill_words;
    assign level_ok = level > CNT_W'(wml);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:       if (xfer_start) state_nx = S_WAIT_LEVEL;
            S_WAIT_LEVEL: begin
                if (blk_q == '0)                        state_nx = S_IDLE;
                else if (level_ok && (limit != '0))     state_nx = S_REQUEST;
            end
            S_REQUEST:    if (req_ready)  state_nx = S_BURSTING;
            S_BURSTING:   if (burst_done) state_nx = S_WAIT_LEVEL;
            default:      state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            blk_q  <= '0;
            desc_q <= '0;
            len_q  <= '0;
            kind_q <= KIND_INCR;
        end else begin
            unique case (state)
                S_IDLE: if (xfer_start) begin
                    addr_q <= start_addr;
                    blk_q  <= blk_words;
                    desc_q <= desc_words;
                end
                S_WAIT_LEVEL: if (state_nx == S_REQUEST) begin
                    len_q  <= limit;
                    kind_q <= kind_c;
                end
                S_BURSTING: if (burst_done) begin
                    addr_q <= addr_q + (ADDR_W'(len_q) << 2);
                    blk_q  <= blk_q - len_q;
                    if (adma_en) desc_q <= desc_q - len_q;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        req_valid = (state == S_REQUEST);
        req_addr  = req_valid ? addr_q : '0;
        req_len   = req_valid ? len_q  : '0;
        req_kind  = req_valid ? kind_q : KIND_INCR;
    end
endmodule

// File: rtl/burst_planner_chk.sv
module burst_planner_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [CNT_W-1:0]  req_len,
    input logic [2:0]        req_kind
);
    a_r9_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_kind));

    a_r7_nonzero_len: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_len != '0);

    a_r3_no_kb_cross: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ({1'b0, req_addr[9:0]} + (11'(req_len) << 2)) <= 11'd1024);

    a_r6_kind_code: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_kind == ((req_len == 4) ? 3'b011 : (req_len == 8) ? 3'b101 : 3'b001)));

    a_r10_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> !req_valid);
endmodule

bind burst_planner burst_planner_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .req_valid(req_valid),
    .req_addr (req_addr),
    .req_len  (req_len),
    .req_kind (req_kind)
);

// File: tb/test_burst_planner.sv
module test_burst_planner;
    localparam int ADDR_W = 32;
    localparam int CNT_W  = 16;
    localparam int LEN_W  = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic xfer_start = 0, adma_en = 0, dir_write = 0, req_ready = 0, burst_done = 0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [CNT_W-1:0]  blk_words = '0, desc_words = '0, fill_words = '0, free_words = '0;
    logic [LEN_W-1:0]  wml = '0, cfg_burst = '0;
    logic              req_valid;
    logic [ADDR_W-1:0] req_addr;
    logic [CNT_W-1:0]  req_len;
    logic [2:0]        req_kind;

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    burst_planner #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) i_burst_planner (.*);

    // Behavioural reference model
    int m_st = 0;
    longint m_addr = 0, m_blk = 0, m_desc = 0, m_len = 0;

    function automatic longint lmin(longint a, longint b);
        return (a < b) ? a : b;
    endfunction

    function automatic int kind_of(longint len);
        if (len == 4) return 3;
        if (len == 8) return 5;
        return 1;
    endfunction

    always @(posedge clk) begin
        longint lim, lvl;
        if (!rst_n) m_st = 0;
        else begin
            case (m_st)
                0: if (xfer_start) begin
                    m_addr = start_addr; m_blk = blk_words; m_desc = desc_words; m_st = 1;
                end
                1: begin
                    lvl = dir_write ? free_words : fill_words;
                    lim = lmin(lmin(cfg_burst, wml), lmin(m_blk, (1024 - (m_addr % 1024)) / 4));
                    if (adma_en) lim = lmin(lim, m_desc);
                    if (m_blk == 0) m_st = 0;
                    else if (lvl > wml && lim > 0) begin m_len = lim; m_st = 2; end
                end
                2: if (req_ready) m_st = 3;
                3: if (burst_done) begin
                    m_addr = m_addr + 4 * m_len;
                    m_blk = m_blk - m_len;
                    if (adma_en) m_desc = m_desc - m_len;
                    m_st = 1;
                end
                default: m_st = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            checks++;
            if (req_valid !== (m_st == 2)) begin
                errors++;
                $display("FAIL R1 model valid: actual=%0b expected=%0b", req_valid, (m_st == 2));
            end else if (req_valid) begin
                if (req_len != m_len || req_addr != m_addr[ADDR_W-1:0] || req_kind != kind_of(m_len)) begin
                    errors++;
                    $display("FAIL R3 model fields: actual len=%0d addr=%h kind=%0d expected len=%0d addr=%h kind=%0d",
                             req_len, req_addr, req_kind, m_len, m_addr, kind_of(m_len));
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic open_xfer(input longint a, input longint blk, input longint desc);
        @(negedge clk);
        start_addr = a[ADDR_W-1:0]; blk_words = blk[CNT_W-1:0]; desc_words = desc[CNT_W-1:0]; xfer_start = 1;
        @(negedge clk);
        xfer_start = 0;
    endtask

    task automatic take_burst(input longint len, input longint a, input int kind, input int hold, input string tag);
        int w = 0;
        while (!req_valid && w < 40) begin @(negedge clk); w++; end
        check(req_valid == 1, {tag, " valid"}, req_valid, 1);
        check(req_len == len, {tag, " len"}, req_len, len);
        check(req_addr == a[ADDR_W-1:0], {tag, " addr"}, req_addr, a);
        check(req_kind == kind, {tag, " kind"}, req_kind, kind);
        for (int i = 0; i < hold; i++) begin
            xfer_start = (i == 1); start_addr = 32'h0000_9000;
            @(negedge clk);
        end
        xfer_start = 0;
        if (hold > 0) begin
            // R9: fields unchanged across the hold and the stray start pulse
            check(req_valid == 1 && req_addr == a[ADDR_W-1:0], "R9 held addr", req_addr, a);
            check(req_len == len, "R9 held len", req_len, len);
        end
        req_ready = 1; @(negedge clk); req_ready = 0;
        @(negedge clk); @(negedge clk);
        burst_done = 1; @(negedge clk); burst_done = 0;
    endtask

    task automatic expect_quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(req_valid == 0, tag, req_valid, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_valid == 0, "R10 reset", req_valid, 0);
        rst_n = 1;
        @(negedge clk);
        check(req_valid == 0, "R10 idle", req_valid, 0);

        // Configured length wins, then block remainder
        cfg_burst = 8; wml = 16; fill_words = 3;
        open_xfer(32'h1000, 20, 0);
        expect_quiet(5, "R1 below watermark");
        fill_words = 16;
        expect_quiet(3, "R1 equal watermark");
        fill_words = 17;
        take_burst(8, 32'h1000, 5, 0, "R6 incr8");
        take_burst(8, 32'h1020, 5, 0, "R8 step");
        take_burst(4, 32'h1040, 3, 0, "R3 block limit");
        expect_quiet(4, "R11 done");

        // 1 KB line
        open_xfer(32'h13F4, 10, 0);
        take_burst(3, 32'h13F4, 1, 0, "R3 kb limit");
        take_burst(7, 32'h1400, 1, 0, "R8 after kb");
        expect_quiet(3, "R11 done kb");

        // Write direction
        dir_write = 1; fill_words = 40; free_words = 2;
        open_xfer(32'h3000, 8, 0);
        expect_quiet(6, "R2 fill ignored");
        free_words = 20;
        take_burst(8, 32'h3000, 5, 0, "R2 free space");
        dir_write = 0;

        // Descriptor limit
        adma_en = 1;
        open_xfer(32'h2000, 12, 5);
        take_burst(5, 32'h2000, 1, 0, "R4 desc limit");
        expect_quiet(8, "R7 desc empty");
        adma_en = 0;
        take_burst(7, 32'h2014, 1, 0, "R5 desc ignored");
        expect_quiet(3, "R11 done desc");

        // Zero watermark gives a zero limit
        wml = 0; fill_words = 5;
        open_xfer(32'h5000, 4, 0);
        expect_quiet(6, "R7 zero wml");
        wml = 4;
        take_burst(4, 32'h5000, 3, 0, "R6 incr4");

        // Hold while not ready, stray start ignored
        wml = 16; fill_words = 40;
        open_xfer(32'h4000, 8, 0);
        take_burst(8, 32'h4000, 5, 5, "R9 hold");
        expect_quiet(3, "R9 stray start");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule